// File: doc/BRIEF.md
# Run-Time Formatted Fixed-Point Adder

This block adds two signed 32-bit operands and requantizes the sum into a number format chosen while the hardware runs. The result width, the binary point position, the overflow policy and the pipeline depth are all fields of a format register loaded through a write strobe. A host can sweep precision, range and latency on live hardware, with no need to rebuild the circuit.

Operands are presented with a single valid bit, one sample per cycle, and no back-pressure. Each result comes out with a valid bit after the selected number of register stages. In saturate mode a one-cycle overflow flag accompanies every clipped result. A format write that arrives while samples are still in the pipeline is parked. It takes effect only once the pipeline has drained, so every sample is processed in one consistent format.

Top module: `fxq_unit`

## Requirements
- R1: After reset, out_valid and out_ovf are low. The active format is 32 result bits, shift 0, wrap mode and latency 1.
- R2: The sum a+b (33-bit signed) is shifted right arithmetically by the shift field, which gives floor((a+b)/2^shift). When this value fits the active width, out_data is that value sign-extended to 32 bits.
- R3: In wrap mode (sat field 0), out_data is the low W bits of the shifted sum, sign-extended from bit W-1. W is the active width.
- R4: In saturate mode (sat field 1), a shifted sum above 2^(W-1)-1 gives 2^(W-1)-1 and a sum below -2^(W-1) gives -2^(W-1), both sign-extended. out_ovf is high on exactly those output cycles. It is never high in wrap mode and never high for a value that fits.
- R5: The width field is 6 bits wide. Written values below 4 act as 4, and values above 32 act as 32.
- R6: With latency field L (0 to 3), a sample presented with in_valid in cycle n produces out_valid in cycle n+L, and back-to-back samples produce back-to-back results. With L=0 the output is combinational from the inputs. out_valid is never high without a matching input sample.
- R7: A format write is applied at the clock edge where no sample is in the pipeline and in_valid is low. If the write comes at any other time, it is held until that condition arises. Samples already in flight are finished in the old format. When several writes are held, the last one wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Format write strobe |
| cfg_width | input | 6 | Requested result width in bits |
| cfg_shift | input | 5 | Number of fractional bits removed from the sum |
| cfg_sat | input | 1 | 1 = saturate on overflow, 0 = wrap |
| cfg_lat | input | 2 | Number of register stages, 0 to 3 |
| in_valid | input | 1 | Operand sample present |
| in_a | input | 32 | Signed operand A |
| in_b | input | 32 | Signed operand B |
| out_valid | output | 1 | Result present |
| out_data | output | 32 | Result, sign-extended from the active width |
| out_ovf | output | 1 | Result was clipped (saturate mode only) |

## Verification
The hardest case to reach is a format write that lands while samples are still travelling through a deep pipeline, because the change must stay deferred. The bench therefore selects latency 3 and streams a burst. It raises the write strobe in the middle of the burst, twice with different formats, and checks that every sample in flight comes out in the old format. After the pipeline drains, it checks that later samples use the second written format, including its new latency. Around this case, a sweep over widths, including clamped out-of-range values, and over shifts, both overflow modes and all four latencies applies extreme, random and small operands against an arithmetic model.

// File: rtl/fxq_pkg.sv
package fxq_pkg;
    parameter int DATA_W  = 32;
    parameter int MIN_W   = 4;
    parameter int MAX_LAT = 3;

    localparam int SUM_W    = DATA_W + 1;
    localparam int WID_BITS = $clog2(DATA_W + 1);
    localparam int SH_BITS  = $clog2(DATA_W);
    localparam int LAT_BITS = $clog2(MAX_LAT + 1);

    typedef struct packed {
        logic [WID_BITS-1:0] width;
        logic [SH_BITS-1:0]  shift;
        logic                sat;
        logic [LAT_BITS-1:0] lat;
    } fmt_t;

    typedef struct packed {
        logic              vld;
        logic              ovf;
        logic [DATA_W-1:0] data;
    } beat_t;

    localparam fmt_t FMT_RESET = '{width: WID_BITS'(DATA_W), shift: '0,
                                   sat: 1'b0, lat: LAT_BITS'(1)};

    function automatic fmt_t fmt_norm(input fmt_t f);
        fmt_t r;
        r = f;
        if (f.width < WID_BITS'(MIN_W))
            r.width = WID_BITS'(MIN_W);
        else if (f.width > WID_BITS'(DATA_W))
            r.width = WID_BITS'(DATA_W);
        return r;
    endfunction
endpackage

// File: rtl/fxq_cfg.sv
module fxq_cfg
    import fxq_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic we,
    input  fmt_t wr_fmt,
    input  logic busy,
    input  logic in_valid,
    output fmt_t act_fmt
);
    logic pend_q;
    fmt_t pend_fmt_q;
    logic quiet;

    assign quiet = !busy && !in_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            act_fmt    <= FMT_RESET;
            pend_q     <= 1'b0;
            pend_fmt_q <= FMT_RESET;
        end else if (quiet) begin
            if (we)
                act_fmt <= fmt_norm(wr_fmt);
            else if (pend_q)
                act_fmt <= pend_fmt_q;
            pend_q <= 1'b0;
        end else if (we) begin
            pend_q     <= 1'b1;
            pend_fmt_q <= fmt_norm(wr_fmt);
        end
    end
endmodule

// File: rtl/fxq_quant.sv
module fxq_quant
    import fxq_pkg::*;
(
    input  fmt_t              fmt,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] data,
    output logic              ovf
);
    localparam logic signed [SUM_W-1:0] ONE = SUM_W'(1);

    logic signed [SUM_W-1:0] sum, shd, hi, lo, wrp, res;
    logic [WID_BITS-1:0]     pad;
    logic                    above, below;

    always_comb begin
        sum   = $signed({a[DATA_W-1], a}) + $signed({b[DATA_W-1], b});
        shd   = sum >>> fmt.shift;
        hi    = (ONE <<< (fmt.width - WID_BITS'(1))) - ONE;
        lo    = ~hi;
        pad   = WID_BITS'(SUM_W) - fmt.width;
        wrp   = (shd <<< pad) >>> pad;
        above = shd > hi;
        below = shd < lo;
        if (!fmt.sat)
            res = wrp;
        else if (above)
            res = hi;
        else if (below)
            res = lo;
        else
            res = shd;
        data = res[DATA_W-1:0];
        ovf  = fmt.sat && (above || below);
    end
endmodule

// File: rtl/fxq_delay.sv
module fxq_delay
    import fxq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [LAT_BITS-1:0] lat,
    input  beat_t               d,
    output beat_t               q,
    output logic                busy
);
    beat_t stg [1:MAX_LAT];
    logic [MAX_LAT-1:0] occ;

    generate
        for (genvar i = 1; i <= MAX_LAT; i++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst)
                    stg[i] <= '0;
                else if (i == 1)
                    stg[i] <= d;
                else
                    stg[i] <= stg[(i > 1) ? i - 1 : 1];
            end
            assign occ[i-1] = stg[i].vld;
        end
    endgenerate

    assign busy = |occ;

    always_comb begin
        q = d;
        for (int i = 1; i <= MAX_LAT; i++)
            if (lat == LAT_BITS'(i))
                q = stg[i];
    end
endmodule

// File: rtl/fxq_unit.sv
module fxq_unit
    import fxq_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cfg_we,
    input  logic [WID_BITS-1:0] cfg_width,
    input  logic [SH_BITS-1:0]  cfg_shift,
    input  logic                cfg_sat,
    input  logic [LAT_BITS-1:0] cfg_lat,
    input  logic                in_valid,
    input  logic [DATA_W-1:0]   in_a,
    input  logic [DATA_W-1:0]   in_b,
    output logic                out_valid,
    output logic [DATA_W-1:0]   out_data,
    output logic                out_ovf
);
    fmt_t  wr_fmt, act_fmt;
    beat_t head, tail;
    logic  pipe_busy;
    logic [DATA_W-1:0] q_data;
    logic  q_ovf;

    assign wr_fmt = '{width: cfg_width, shift: cfg_shift, sat: cfg_sat, lat: cfg_lat};

    fxq_cfg u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .wr_fmt(wr_fmt),
        .busy(pipe_busy), .in_valid(in_valid), .act_fmt(act_fmt)
    );

    fxq_quant u_quant (
        .fmt(act_fmt), .a(in_a), .b(in_b), .data(q_data), .ovf(q_ovf)
    );

    assign head = '{vld: in_valid, ovf: q_ovf && in_valid, data: q_data};

    fxq_delay u_delay (
        .clk(clk), .rst(rst), .lat(act_fmt.lat), .d(head), .q(tail), .busy(pipe_busy)
    );

    assign out_valid = tail.vld;
    assign out_data  = tail.data;
    assign out_ovf   = tail.vld && tail.ovf;
endmodule

// File: rtl/fxq_unit_chk.sv
module fxq_unit_chk
    import fxq_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              out_valid,
    input logic [DATA_W-1:0] out_data,
    input logic              out_ovf,
    input fmt_t              act_fmt,
    input logic              pipe_busy
);
    function automatic bit fits(input logic [DATA_W-1:0] v, input logic [WID_BITS-1:0] w);
        longint s, h;
        s = longint'($signed(v));
        h = (64'sd1 <<< (w - 1)) - 64'sd1;
        return (s <= h) && (s >= -h - 64'sd1);
    endfunction

    function automatic bit extreme(input logic [DATA_W-1:0] v, input logic [WID_BITS-1:0] w);
        longint s, h;
        s = longint'($signed(v));
        h = (64'sd1 <<< (w - 1)) - 64'sd1;
        return (s == h) || (s == -h - 64'sd1);
    endfunction

    AST_RESULT_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> fits(out_data, act_fmt.width)); // R3

    AST_OVF_ONLY_SAT: assert property (@(posedge clk) disable iff (rst)
        out_ovf |-> (out_valid && act_fmt.sat)); // R4

    AST_OVF_CLIPPED: assert property (@(posedge clk) disable iff (rst)
        out_ovf |-> extreme(out_data, act_fmt.width)); // R4

    AST_WIDTH_CLAMPED: assert property (@(posedge clk) disable iff (rst)
        (act_fmt.width >= WID_BITS'(MIN_W)) && (act_fmt.width <= WID_BITS'(DATA_W))); // R5

    AST_LAT0_PASS: assert property (@(posedge clk) disable iff (rst)
        (act_fmt.lat == '0) |-> (out_valid == in_valid)); // R6

    AST_LAT1_FOLLOW: assert property (@(posedge clk) disable iff (rst)
        (act_fmt.lat == LAT_BITS'(1) && in_valid) |=> out_valid); // R6

    AST_FMT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (pipe_busy || in_valid) |=> $stable(act_fmt)); // R7
endmodule

bind fxq_unit fxq_unit_chk u_chk (
    .clk(clk), .rst(rst), .in_valid(in_valid), .out_valid(out_valid),
    .out_data(out_data), .out_ovf(out_ovf), .act_fmt(act_fmt), .pipe_busy(pipe_busy)
);

// File: tb/fxq_unit_tb.sv
module fxq_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_we = 1'b0;
    logic [5:0]  cfg_width = '0;
    logic [4:0]  cfg_shift = '0;
    logic        cfg_sat = 1'b0;
    logic [1:0]  cfg_lat = '0;
    logic        in_valid = 1'b0;
    logic [31:0] in_a = '0, in_b = '0;
    logic        out_valid, out_ovf;
    logic [31:0] out_data;

    int nvec = 0, nbad = 0, cyc = 0;
    int cw = 32, csh = 0, clat = 1;
    bit csat = 1'b0;
    logic [31:0] rng = 32'h1234_5679;

    logic [31:0] q_d[$];
    bit          q_o[$];
    int          q_c[$];
    int          q_l[$];
    string       q_r[$];

    fxq_unit u_dut (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_width(cfg_width),
        .cfg_shift(cfg_shift), .cfg_sat(cfg_sat), .cfg_lat(cfg_lat),
        .in_valid(in_valid), .in_a(in_a), .in_b(in_b),
        .out_valid(out_valid), .out_data(out_data), .out_ovf(out_ovf)
    );

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic int eff_w(input int w);
        return (w < 4) ? 4 : ((w > 32) ? 32 : w);
    endfunction

    function automatic void model(input logic [31:0] a, input logic [31:0] b, input int w,
                                  input int sh, input bit sat,
                                  output logic [31:0] r, output bit ovf);
        longint s, hi, lo, t;
        s  = longint'($signed(a)) + longint'($signed(b));
        s  = s >>> sh;
        hi = (64'sd1 <<< (w - 1)) - 64'sd1;
        lo = -hi - 64'sd1;
        ovf = 1'b0;
        if (sat) begin
            if (s > hi) begin t = hi; ovf = 1'b1; end
            else if (s < lo) begin t = lo; ovf = 1'b1; end
            else t = s;
        end else begin
            t = s & ((64'sd1 <<< w) - 64'sd1);
            if (t[w-1]) t = t - (64'sd1 <<< w);
        end
        r = t[31:0];
    endfunction

    function automatic logic [31:0] nxt(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    // monitor: samples 2 ns after the falling edge
    always @(negedge clk) begin
        #2;
        if (!rst && out_valid) begin
            nvec++;
            if (q_d.size() == 0) begin
                nbad++;
                $display("FAIL R6 unexpected out_valid data=%h exp=none", out_data);
            end else begin
                logic [31:0] ed;
                bit eo;
                int ec, el;
                string tg;
                ed = q_d.pop_front(); eo = q_o.pop_front();
                ec = q_c.pop_front(); el = q_l.pop_front(); tg = q_r.pop_front();
                if (out_data !== ed || out_ovf !== eo || (cyc - ec) != el) begin
                    nbad++;
                    $display("FAIL %s R6 data=%h exp=%h ovf=%b exp=%b lat=%0d exp=%0d",
                             tg, out_data, ed, out_ovf, eo, cyc - ec, el);
                end
            end
        end
    end

    task automatic push_exp(input logic [31:0] a, input logic [31:0] b, input string extra);
        logic [31:0] r;
        bit o;
        string tg;
        model(a, b, eff_w(cw), csh, csat, r, o);
        tg = csat ? "R2 R4" : "R2 R3";
        if (cw < 4 || cw > 32) tg = {tg, " R5"};
        q_d.push_back(r); q_o.push_back(o); q_c.push_back(cyc);
        q_l.push_back(clat); q_r.push_back({tg, extra});
    endtask

    task automatic send(input logic [31:0] a, input logic [31:0] b);
        @(negedge clk);
        in_valid = 1'b1; in_a = a; in_b = b;
        push_exp(a, b, "");
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0; cfg_we = 1'b0;
        end
    endtask

    task automatic put_cfg(input int w, input int sh, input bit sat, input int lat);
        cfg_width = 6'(w); cfg_shift = 5'(sh); cfg_sat = sat; cfg_lat = 2'(lat);
    endtask

    task automatic set_cfg(input int w, input int sh, input bit sat, input int lat);
        @(negedge clk);
        in_valid = 1'b0; cfg_we = 1'b1;
        put_cfg(w, sh, sat, lat);
        @(negedge clk);
        cfg_we = 1'b0;
        cw = w; csh = sh; csat = sat; clat = lat;
    endtask

    int wl[7] = '{2, 4, 5, 9, 16, 32, 40};
    int sl[4] = '{0, 1, 4, 31};

    initial begin
        #(8 * 200000);
        nbad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        #2;
        nvec++;
        if (out_valid !== 1'b0 || out_ovf !== 1'b0) begin
            nbad++;
            $display("FAIL R1 reset outputs valid=%b ovf=%b exp=0 0", out_valid, out_ovf);
        end
        // R1: default format, latency 1, full width wrap
        send(32'h7fff_ffff, 32'h0000_0001);
        send(32'hffff_fff0, 32'h0000_0003);
        idle(5);

        // sweep R2 R3 R4 R5 R6
        foreach (wl[iw]) foreach (sl[is]) for (int sm = 0; sm < 2; sm++)
            for (int lt = 0; lt < 4; lt++) begin
                int ew;
                ew = eff_w(wl[iw]);
                set_cfg(wl[iw], sl[is], sm[0], lt);
                send(32'h7fff_ffff, 32'h7fff_ffff);
                send(32'h8000_0000, 32'h8000_0000);
                send(32'hffff_ffff, 32'h0000_0000);
                send(32'h0000_0001, 32'hffff_fffe);
                for (int k = 0; k < 8; k++) begin
                    logic [31:0] ra, rb;
                    rng = nxt(rng); ra = rng;
                    rng = nxt(rng); rb = rng;
                    if (k[0]) begin
                        ra = 32'($signed(ra) >>> (33 - ew)) << sl[is];
                        rb = 32'($signed(rb) >>> (33 - ew)) << sl[is];
                    end
                    send(ra, rb);
                end
                idle(6);
            end

        // R7: writes during a busy latency-3 burst are deferred, last one wins
        set_cfg(32, 0, 1'b0, 3);
        send(32'h4000_0000, 32'h4000_0000);
        @(negedge clk);
        in_valid = 1'b1; in_a = 32'h7000_0000; in_b = 32'h7000_0000;
        cfg_we = 1'b1; put_cfg(6, 2, 1'b1, 2);
        push_exp(in_a, in_b, " R7");
        @(negedge clk);
        in_a = 32'h8000_0000; in_b = 32'hffff_ffff;
        cfg_we = 1'b0;
        push_exp(in_a, in_b, " R7");
        @(negedge clk);
        in_valid = 1'b0; cfg_we = 1'b1; put_cfg(8, 1, 1'b1, 0);
        @(negedge clk);
        cfg_we = 1'b0;
        idle(6);
        cw = 8; csh = 1; csat = 1'b1; clat = 0;
        @(negedge clk);
        in_valid = 1'b1; in_a = 32'h0000_0400; in_b = 32'h0000_0000;
        push_exp(in_a, in_b, " R7");
        @(negedge clk);
        in_a = 32'hffff_fc00; in_b = 32'h0000_0001;
        push_exp(in_a, in_b, " R7");
        @(negedge clk);
        in_a = 32'h0000_0031; in_b = 32'h0000_0002;
        push_exp(in_a, in_b, " R7");
        idle(6);

        nvec++;
        if (q_d.size() != 0) begin
            nbad++;
            $display("FAIL R6 missing results count=%0d exp=0", q_d.size());
        end
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule